// File: doc/BRIEF.md
# Increment-and-Skip Execution Unit

This unit carries out two byte-wide microcontroller operations: add one to a data byte and then discard the next instruction when the sum is zero, or add one and discard it when the sum is nonzero. It accepts a 16-bit instruction word through a valid/ready exchange. Each instruction cycle takes four clocks: decode, fetch the operand, add one, and store the result. The sum goes either into the working byte register or back into the data byte it came from.

The operand location comes from one of three address forms: a banked form that uses the bank select input, an access-window form that splits the 8-bit address between the lowest and the highest bank, and an indexed form that adds the field to an index value. When the next instruction is discarded, the unit spends one or two more idle instruction cycles, depending on whether that instruction is one or two words long. The program counter moves ahead over every word it passes. A load and probe port lets the surrounding logic preload and observe the data bytes and the working register. No flags are produced.

Top module: `isk_exec_unit`

## Requirements
- R1: Bits [15:10] of the instruction word select the operation: 6'b001111 means add one and skip when the result is zero, and 6'b010010 means add one and skip when the result is nonzero. Bit 9 is the destination bit, bit 8 is the bank bit and bits [7:0] are the byte address field. Any other pattern runs as one empty instruction cycle: the program counter advances by one, and neither the working register nor the data memory changes.
- R2: The result is the operand byte plus one, modulo 256. With bit 9 = 1 the result is stored at the operand location and the working register does not change. With bit 9 = 0 the result goes to the working register and the data memory does not change.
- R3: The zero form reports a skip exactly when the result is 8'h00. The nonzero form reports a skip exactly when the result is not 8'h00. The `skipped` output holds this outcome from the `done` pulse until the next accept.
- R4: The `done` pulse appears 4 clocks after the accept edge when there is no skip. With a skip it appears after 8 clocks if `next_two_word` = 0, and after 12 clocks if `next_two_word` = 1. `ready` is high only while the unit is idle.
- R5: Every instruction cycle steps `phase` through 0, 1, 2, 3 in order. The data memory changes only at the clock edge that ends phase 3.
- R6: With bank bit = 1 the operand address is {bsr_in, field}.
- R7: With bank bit = 0 and the indexed form not in use, a field below 8'h60 addresses bank 0 at that field, and a field of 8'h60 or more addresses the highest bank at that field.
- R8: With `ext_en` = 1, bank bit = 0 and a field of 8'h5F or less, the operand address is idx_in + field, wrapping within the data memory size.
- R9: The program counter advances by 1 without a skip, by 2 when a one-word instruction is skipped, and by 3 when a two-word instruction is skipped.
- R10: After reset `pc` = PC_RESET (0), `wreg` = 8'h00, `ready` = 1 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction word |
| next_two_word | input | 1 | The following instruction is two words long |
| ext_en | input | 1 | Enables the indexed address form |
| bsr_in | input | BSEL_W | Bank select value |
| idx_in | input | AW | Index register value |
| wload_en | input | 1 | Loads the working register |
| wload_data | input | 8 | Value for the working register |
| mload_en | input | 1 | Writes a data byte |
| mload_addr | input | AW | Address for the data byte write |
| mload_data | input | 8 | Data byte to write |
| probe_addr | input | AW | Address for the data byte read |
| probe_data | output | 8 | Data byte at probe_addr |
| ready | output | 1 | Idle and able to accept |
| done | output | 1 | One-clock pulse when an instruction ends |
| skipped | output | 1 | The last instruction discarded its successor |
| phase | output | 2 | Current phase within the instruction cycle |
| wreg | output | 8 | Working register |
| pc | output | PC_W | Program counter in words |

## Verification
The bench uses the default build: four banks, an access split at 8'h60, the indexed form enabled and a 16-bit counter. With four banks the highest bank is bank 3, so the banked, access-low and access-high paths land on three different addresses. The 1024-byte memory makes the index wrap reachable with an index near 10'h3FF. Indexed operations with the split field values 8'h5F and 8'h60 exercise both sides of the boundary.

// File: rtl/isk_pkg.sv
package isk_pkg;

   localparam logic [5:0] OPC_INC_SKZ  = 6'b001111;
   localparam logic [5:0] OPC_INC_SKNZ = 6'b010010;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EXEC  = 2'd1,
      ST_FLUSH = 2'd2
   } isk_state_t;

   localparam logic [1:0] PH_DECODE = 2'd0;
   localparam logic [1:0] PH_READ   = 2'd1;
   localparam logic [1:0] PH_PROC   = 2'd2;
   localparam logic [1:0] PH_WRITE  = 2'd3;

   typedef struct packed {
      logic       on_zero;
      logic       on_nonzero;
      logic       to_file;
      logic       banked;
      logic [7:0] field;
   } isk_fields_t;

endpackage

// File: rtl/isk_decode.sv
module isk_decode
   import isk_pkg::*;
(
   input  logic [15:0] word,
   output isk_fields_t fields
);
   logic [5:0] opc;

   always_comb begin
      opc               = word[15:10];
      fields.on_zero    = (opc == OPC_INC_SKZ);
      fields.on_nonzero = (opc == OPC_INC_SKNZ);
      fields.to_file    = word[9];
      fields.banked     = word[8];
      fields.field      = word[7:0];
   end
endmodule

// File: rtl/isk_addr_gen.sv
module isk_addr_gen #(
   parameter int BANK_COUNT   = 4,
   parameter int ACCESS_SPLIT = 96,
   parameter bit INDEX_EN     = 1'b1,
   localparam int BSEL_W      = $clog2(BANK_COUNT),
   localparam int AW          = 8 + BSEL_W
) (
   input  logic              banked,
   input  logic [7:0]        field,
   input  logic [BSEL_W-1:0] bsr,
   input  logic [AW-1:0]     idx,
   input  logic              ext_en,
   output logic [AW-1:0]     addr
);
   localparam logic [BSEL_W-1:0] TOP_BANK = BSEL_W'(BANK_COUNT - 1);
   localparam logic [8:0]        SPLIT_V  = 9'(ACCESS_SPLIT);

   logic          low_half;
   logic [AW-1:0] access_addr;
   logic [AW-1:0] index_addr;
   logic          use_index;

   assign low_half    = ({1'b0, field} < SPLIT_V);
   assign access_addr = low_half ? {{BSEL_W{1'b0}}, field} : {TOP_BANK, field};

   generate
      if (INDEX_EN) begin : g_index
         assign index_addr = idx + {{BSEL_W{1'b0}}, field};
         assign use_index  = ext_en & ~banked & low_half;
      end else begin : g_no_index
         logic unused_ok;
         assign unused_ok  = ext_en ^ (^idx);
         assign index_addr = '0;
         assign use_index  = 1'b0;
      end
   endgenerate

   always_comb begin
      if (banked)         addr = {bsr, field};
      else if (use_index) addr = index_addr;
      else                addr = access_addr;
   end
endmodule

// File: rtl/isk_regfile.sv
module isk_regfile #(
   parameter int AW = 10,
   parameter int DW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata,
   input  logic [AW-1:0] paddr,
   output logic [DW-1:0] pdata
);
   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
   assign pdata = cells[paddr];
endmodule

// File: rtl/isk_exec_unit.sv
module isk_exec_unit
   import isk_pkg::*;
#(
   parameter int BANK_COUNT   = 4,
   parameter int ACCESS_SPLIT = 96,
   parameter bit INDEX_EN     = 1'b1,
   parameter int PC_W         = 16,
   parameter logic [PC_W-1:0] PC_RESET = '0,
   localparam int BSEL_W      = $clog2(BANK_COUNT),
   localparam int AW          = 8 + BSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [15:0]       instr_word,
   input  logic              next_two_word,
   input  logic              ext_en,
   input  logic [BSEL_W-1:0] bsr_in,
   input  logic [AW-1:0]     idx_in,
   input  logic              wload_en,
   input  logic [7:0]        wload_data,
   input  logic              mload_en,
   input  logic [AW-1:0]     mload_addr,
   input  logic [7:0]        mload_data,
   input  logic [AW-1:0]     probe_addr,
   output logic [7:0]        probe_data,
   output logic              ready,
   output logic              done,
   output logic              skipped,
   output logic [1:0]        phase,
   output logic [7:0]        wreg,
   output logic [PC_W-1:0]   pc
);
   generate
      if (BANK_COUNT < 2 || BANK_COUNT > 16 || (BANK_COUNT & (BANK_COUNT - 1)) != 0) begin : g_bad_banks
         $error("isk_exec_unit: BANK_COUNT must be a power of two from 2 to 16");
      end
      if (ACCESS_SPLIT < 1 || ACCESS_SPLIT > 256) begin : g_bad_split
         $error("isk_exec_unit: ACCESS_SPLIT must lie in 1..256");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("isk_exec_unit: PC_W must be at least 2");
      end
   endgenerate

   isk_state_t        state_q;
   logic [1:0]        phase_q;
   isk_fields_t       dec_f;
   isk_fields_t       op_q;
   logic              two_q;
   logic              ext_q;
   logic [BSEL_W-1:0] bsr_q;
   logic [AW-1:0]     idx_q;
   logic [AW-1:0]     gen_addr;
   logic [AW-1:0]     addr_q;
   logic [7:0]        rd_data;
   logic [7:0]        rd_q;
   logic [7:0]        res_q;
   logic [7:0]        inc_v;
   logic              skip_now;
   logic              skip_q;
   logic              flush_left_q;
   logic              done_q;
   logic              skipped_q;
   logic [7:0]        wreg_q;
   logic [PC_W-1:0]   pc_q;
   logic              op_known;
   logic              exec_we;
   logic              mem_we;
   logic [AW-1:0]     mem_waddr;
   logic [7:0]        mem_wdata;

   isk_decode u_decode (
      .word   (instr_word),
      .fields (dec_f)
   );

   isk_addr_gen #(
      .BANK_COUNT   (BANK_COUNT),
      .ACCESS_SPLIT (ACCESS_SPLIT),
      .INDEX_EN     (INDEX_EN)
   ) u_addr (
      .banked (op_q.banked),
      .field  (op_q.field),
      .bsr    (bsr_q),
      .idx    (idx_q),
      .ext_en (ext_q),
      .addr   (gen_addr)
   );

   assign op_known = op_q.on_zero | op_q.on_nonzero;
   assign exec_we  = (state_q == ST_EXEC) && (phase_q == PH_WRITE) && op_q.to_file && op_known;

   always_comb begin
      if (exec_we) begin
         mem_we    = 1'b1;
         mem_waddr = addr_q;
         mem_wdata = res_q;
      end else begin
         mem_we    = mload_en;
         mem_waddr = mload_addr;
         mem_wdata = mload_data;
      end
   end

   isk_regfile #(
      .AW (AW),
      .DW (8)
   ) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (addr_q),
      .rdata (rd_data),
      .paddr (probe_addr),
      .pdata (probe_data)
   );

   assign inc_v    = rd_q + 8'd1;
   assign skip_now = (op_q.on_zero & (inc_v == 8'h00)) | (op_q.on_nonzero & (inc_v != 8'h00));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         phase_q      <= PH_DECODE;
         op_q         <= '0;
         two_q        <= 1'b0;
         ext_q        <= 1'b0;
         bsr_q        <= '0;
         idx_q        <= '0;
         addr_q       <= '0;
         rd_q         <= '0;
         res_q        <= '0;
         skip_q       <= 1'b0;
         flush_left_q <= 1'b0;
         done_q       <= 1'b0;
         skipped_q    <= 1'b0;
         wreg_q       <= '0;
         pc_q         <= PC_RESET;
      end else begin
         done_q <= 1'b0;
         if (wload_en) wreg_q <= wload_data;
         unique case (state_q)
            ST_IDLE: begin
               if (instr_valid) begin
                  op_q      <= dec_f;
                  two_q     <= next_two_word;
                  ext_q     <= ext_en;
                  bsr_q     <= bsr_in;
                  idx_q     <= idx_in;
                  skipped_q <= 1'b0;
                  phase_q   <= PH_DECODE;
                  state_q   <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               phase_q <= phase_q + 2'd1;
               unique case (phase_q)
                  PH_DECODE: addr_q <= gen_addr;
                  PH_READ:   rd_q   <= rd_data;
                  PH_PROC: begin
                     res_q  <= inc_v;
                     skip_q <= skip_now;
                  end
                  PH_WRITE: begin
                     pc_q <= pc_q + PC_W'(1);
                     if (op_known && !op_q.to_file) wreg_q <= res_q;
                     if (skip_q) begin
                        flush_left_q <= two_q;
                        state_q      <= ST_FLUSH;
                     end else begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                     end
                  end
                  default: ;
               endcase
            end
            ST_FLUSH: begin
               phase_q <= phase_q + 2'd1;
               if (phase_q == PH_WRITE) begin
                  pc_q <= pc_q + PC_W'(1);
                  if (flush_left_q) begin
                     flush_left_q <= 1'b0;
                  end else begin
                     done_q    <= 1'b1;
                     skipped_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready   = (state_q == ST_IDLE);
   assign done    = done_q;
   assign skipped = skipped_q;
   assign phase   = phase_q;
   assign wreg    = wreg_q;
   assign pc      = pc_q;

   // Phase order inside busy cycles
   assert_phase_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && phase_q != PH_WRITE) |=> (phase_q == $past(phase_q) + 2'd1));

   // Operand byte must not move before the write phase ends
   assert_mem_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && (phase_q == PH_READ || phase_q == PH_PROC) && !mload_en)
      |=> $stable(rd_data));

   // Skip decision matches the stored result
   assert_skip_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && phase_q == PH_WRITE && skip_q)
      |-> (op_q.on_nonzero ? (res_q != 8'h00) : (op_q.on_zero && res_q == 8'h00)));

   assert_no_skip_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && phase_q == PH_WRITE && !skip_q) |=> (ready && done));

   assert_skip_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && phase_q == PH_WRITE && skip_q) |=> (!ready && !done));

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // Counter moves only at the close of an instruction cycle
   assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE || phase_q != PH_WRITE) |=> $stable(pc_q));
endmodule

// File: tb/tb_isk_exec_unit.sv
`timescale 1ns/1ps
module tb_isk_exec_unit;
   localparam int AW  = 10;
   localparam int BW  = 2;
   localparam int PCW = 16;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           instr_valid;
   logic [15:0]    instr_word;
   logic           next_two_word;
   logic           ext_en;
   logic [BW-1:0]  bsr_in;
   logic [AW-1:0]  idx_in;
   logic           wload_en;
   logic [7:0]     wload_data;
   logic           mload_en;
   logic [AW-1:0]  mload_addr;
   logic [7:0]     mload_data;
   logic [AW-1:0]  probe_addr;
   logic [7:0]     probe_data;
   logic           ready, done, skipped;
   logic [1:0]     phase;
   logic [7:0]     wreg;
   logic [PCW-1:0] pc;

   always #2.5 clk = ~clk;

   isk_exec_unit dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .next_two_word(next_two_word), .ext_en(ext_en), .bsr_in(bsr_in), .idx_in(idx_in),
      .wload_en(wload_en), .wload_data(wload_data), .mload_en(mload_en),
      .mload_addr(mload_addr), .mload_data(mload_data), .probe_addr(probe_addr),
      .probe_data(probe_data), .ready(ready), .done(done), .skipped(skipped),
      .phase(phase), .wreg(wreg), .pc(pc)
   );

   typedef struct {
      logic [AW-1:0]  addr;
      logic [7:0]     old_v;
      logic [7:0]     new_v;
      logic [7:0]     w;
      logic [PCW-1:0] pcv;
      logic           skip;
      int             cycles;
      string          tag;
   } exp_t;

   exp_t           sbq[$];
   int             total = 0;
   int             bad = 0;
   logic [7:0]     mdl_mem [1 << AW];
   logic [7:0]     mdl_w;
   logic [PCW-1:0] mdl_pc;

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load_mem(input logic [AW-1:0] a, input logic [7:0] v);
      mload_en = 1'b1; mload_addr = a; mload_data = v;
      @(negedge clk);
      mload_en = 1'b0;
      mdl_mem[a] = v;
   endtask

   task automatic load_w(input logic [7:0] v);
      wload_en = 1'b1; wload_data = v;
      @(negedge clk);
      wload_en = 1'b0;
      mdl_w = v;
   endtask

   task automatic run_op(input logic [15:0] word, input bit two, input bit ext,
                         input logic [BW-1:0] bsr, input logic [AW-1:0] idx, input string tag);
      exp_t e;
      logic [5:0] opc;
      logic [7:0] f, res;
      bit known, skip;
      opc = word[15:10];
      f   = word[7:0];
      known = (opc == 6'b001111) || (opc == 6'b010010);
      if (word[8])                 e.addr = {bsr, f};
      else if (ext && f <= 8'h5F)  e.addr = idx + AW'(f);
      else if (f < 8'h60)          e.addr = AW'(f);
      else                         e.addr = {2'b11, f};
      e.old_v = mdl_mem[e.addr];
      res = e.old_v + 8'd1;
      skip = (opc == 6'b001111) ? (res == 8'h00) : ((opc == 6'b010010) ? (res != 8'h00) : 1'b0);
      if (known && word[9])  mdl_mem[e.addr] = res;
      if (known && !word[9]) mdl_w = res;
      e.new_v  = mdl_mem[e.addr];
      e.w      = mdl_w;
      e.skip   = skip;
      e.cycles = skip ? (two ? 12 : 8) : 4;
      mdl_pc   = mdl_pc + (skip ? (two ? 16'd3 : 16'd2) : 16'd1);
      e.pcv    = mdl_pc;
      e.tag    = tag;
      sbq.push_back(e);
      instr_word = word; next_two_word = two; ext_en = ext; bsr_in = bsr; idx_in = idx;
      instr_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: pops one expectation per accepted instruction
   initial begin
      exp_t e;
      int n;
      forever begin
         wait (sbq.size() > 0);
         e = sbq.pop_front();
         probe_addr = e.addr;
         @(posedge clk);
         n = 0;
         forever begin
            @(negedge clk);
            if (done || n > 40) break;
            if (n < 4) check(e.tag, "operand held before write R5", probe_data, e.old_v);
            if (n < 4) check(e.tag, "phase sequence R5", phase, n);
            @(posedge clk);
            n++;
         end
         check(e.tag, "clocks to done R4", n, e.cycles);
         check(e.tag, "ready at done R4", ready, 1);
         check(e.tag, "skipped flag R3", skipped, e.skip);
         check(e.tag, "program counter R9", pc, e.pcv);
         check(e.tag, "working register R2", wreg, e.w);
         check(e.tag, "data byte R2", probe_data, e.new_v);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; next_two_word = 1'b0;
      ext_en = 1'b0; bsr_in = '0; idx_in = '0; wload_en = 1'b0; wload_data = '0;
      mload_en = 1'b0; mload_addr = '0; mload_data = '0; probe_addr = '0;
      mdl_w = '0; mdl_pc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "pc after reset", pc, 0);
      check("R10", "wreg after reset", wreg, 0);
      check("R10", "ready after reset", ready, 1);
      check("R10", "done after reset", done, 0);

      // Banked operand, write back, no skip
      load_mem(10'h210, 8'h41);
      run_op(16'h3F10, 1'b0, 1'b0, 2'd2, '0, "R1 R6 R2");
      // Access low, result to W, wraps to zero and skips one word
      load_mem(10'h020, 8'hFF);
      load_w(8'h5A);
      run_op(16'h3C20, 1'b0, 1'b0, 2'd1, '0, "R2 R3 R7 R9");
      // Skip of a two-word successor
      load_mem(10'h030, 8'hFF);
      run_op(16'h3E30, 1'b1, 1'b0, 2'd0, '0, "R4 R9 two-word");
      // Nonzero form, access high goes to top bank
      load_mem(10'h370, 8'h05);
      run_op(16'h4A70, 1'b0, 1'b0, 2'd0, '0, "R7 R3 nonzero");
      // Nonzero form, result zero, no skip
      load_mem(10'h371, 8'hFF);
      run_op(16'h4A71, 1'b1, 1'b0, 2'd0, '0, "R3 R4 no-skip");
      // Indexed form
      load_mem(10'h205, 8'h7F);
      run_op(16'h3E05, 1'b0, 1'b1, 2'd0, 10'h200, "R8 indexed");
      // Split boundary: 5F indexed, 60 not
      load_mem(10'h15F, 8'h10);
      run_op(16'h4A5F, 1'b1, 1'b1, 2'd0, 10'h100, "R8 field 5F");
      load_mem(10'h360, 8'hFF);
      run_op(16'h4A60, 1'b0, 1'b1, 2'd0, 10'h100, "R8 R7 field 60");
      // Index wrap
      load_mem(10'h010, 8'hFE);
      run_op(16'h3E20, 1'b0, 1'b1, 2'd0, 10'h3F0, "R8 wrap");
      // Banked wins over index
      load_mem(10'h105, 8'h22);
      run_op(16'h4905, 1'b1, 1'b1, 2'd1, 10'h200, "R6 banked with ext");
      // Unknown opcodes
      load_mem(10'h011, 8'hFF);
      run_op(16'h3B11, 1'b1, 1'b0, 2'd0, '0, "R1 unknown A");
      run_op(16'h0000, 1'b0, 1'b0, 2'd0, '0, "R1 unknown B");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule